// File: doc/BRIEF.md
# Memory ECC Error Capture Registers

This block records memory errors for software. A memory controller presents the outcome of every 64-bit read as two 32-bit halves. For each half it gives a strobe, the check bits fetched from memory, the syndrome and a flag that separates a correctable single-bit error from an uncorrectable double-bit error. When a transaction fails, the controller also raises an error event. The event carries the failing address and three attributes: whether the CPU or DMA started it, whether it was a read or a write, and whether the cause was an ECC fault or a timeout or overrun.

Software sees two 32-bit registers through a small register bus. The error address register keeps the first failure. Its top bit is the interrupt request. The error syndrome register follows every memory read until a failure is held in the address register, and then it freezes. The frozen value describes the failing read. Any write to either register clears that register, and no write data is involved. Software reads both registers, services the fault, and clears them by writing.

Top module: `ecc_err_log`

## Requirements
- R1: After reset both registers read as zero and `irq` is low.
- R2: When `err_evt` is high and the address register is not valid, the next cycle holds bit 31 = 1, bit 30 = `err_cpu`, bit 29 = `err_write`, bit 28 = `err_ecc`, bit 27 = 0 and bits 26:0 = `err_addr`.
- R3: While the address register is valid, further error events leave it unchanged.
- R4: `irq` is high exactly while bit 31 of the address register is set.
- R5: While the address register is not valid, a half strobe loads that half of the syndrome register. The high half uses bits 31:16 and the low half uses bits 15:0. Inside a half, bit 15 is 1 when the syndrome is nonzero, bits 14:8 hold the check bits, bit 7 holds the single flag (1 = single-bit) and bits 6:0 hold the syndrome. A half without a strobe keeps its value.
- R6: While the address register is valid, the syndrome register holds its value.
- R7: A write with `bus_sel` = 0 clears the address register, and a write with `bus_sel` = 1 clears the syndrome register. In both cases the other register is unchanged. A clearing write beats a syndrome update in the same cycle.
- R8: When a clearing write to the address register and an error event fall in the same cycle, the register becomes zero. An error event on the following cycle is captured.
- R9: A read with `bus_sel` = 0 (address register) or 1 (syndrome register) puts the register's value, as it stands before that clock edge, on `bus_rdata` one cycle later. `bus_rdata` holds until the next read.
- R10: The read that reports an error in the same cycle as `err_evt` still loads the syndrome register, so the frozen syndrome describes the failing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_vld | input | 1 | High word result strobe |
| hi_chk | input | 7 | High word check bits from memory |
| hi_syn | input | 7 | High word syndrome |
| hi_single | input | 1 | High word: 1 single-bit, 0 double-bit |
| lo_vld | input | 1 | Low word result strobe |
| lo_chk | input | 7 | Low word check bits from memory |
| lo_syn | input | 7 | Low word syndrome |
| lo_single | input | 1 | Low word: 1 single-bit, 0 double-bit |
| err_evt | input | 1 | Failed transaction event |
| err_cpu | input | 1 | 1 CPU, 0 DMA |
| err_write | input | 1 | 1 write, 0 read |
| err_ecc | input | 1 | 1 ECC fault, 0 timeout or overrun |
| err_addr | input | 27 | Failing address |
| bus_sel | input | 1 | Register select: 0 address, 1 syndrome |
| bus_wr | input | 1 | Clearing write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same clock edge. An error capture can meet a clearing write to the address register. The syndrome update of a failing read can meet the freeze that the same failure starts. Directed steps drive `err_evt` together with `bus_wr` and `bus_sel` = 0. They check that the register reads zero and that the next event is then taken. Other steps put a low-half strobe in the same cycle as the error and read the frozen syndrome back. Random stimulus then mixes events, strobes, reads and writes freely. Every output is compared against a bench model that takes the clearing write over capture and update, and that bases the freeze on the valid bit from before the edge.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;

   typedef enum logic {
      SEL_ADDR = 1'b0,
      SEL_SYN  = 1'b1
   } reg_sel_e;

   localparam int ATTR_W = 5;

endpackage

// File: rtl/ecc_err_addr_reg.sv
module ecc_err_addr_reg #(
   parameter int ADDR_W = 27,
   localparam int REG_W = ADDR_W + ecc_err_log_pkg::ATTR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_req,
   input  logic              cap_cpu,
   input  logic              cap_write,
   input  logic              cap_ecc,
   input  logic [ADDR_W-1:0] cap_addr,
   input  logic              clr,
   output logic [REG_W-1:0]  ear_q
);

   logic valid;
   logic take;

   assign valid = ear_q[REG_W-1];
   assign take  = cap_req && !valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ear_q <= '0;
      end else if (clr) begin
         ear_q <= '0;
      end else if (take) begin
         ear_q <= {1'b1, cap_cpu, cap_write, cap_ecc, 1'b0, cap_addr};
      end
   end

endmodule

// File: rtl/ecc_err_syn_half.sv
module ecc_err_syn_half #(
   parameter int CODE_W = 7,
   localparam int HALF_W = 2 * CODE_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [CODE_W-1:0] chk,
   input  logic [CODE_W-1:0] syn,
   input  logic              single,
   input  logic              clr,
   output logic [HALF_W-1:0] half_q
);

   logic [HALF_W-1:0] half_d;

   assign half_d = {(|syn), chk, single, syn};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         half_q <= '0;
      end else if (clr) begin
         half_q <= '0;
      end else if (upd) begin
         half_q <= half_d;
      end
   end

endmodule

// File: rtl/ecc_err_rd_port.sv
module ecc_err_rd_port #(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd,
   input  logic             sel,
   input  logic [REG_W-1:0] ear_q,
   input  logic [REG_W-1:0] esr_q,
   output logic [REG_W-1:0] rdata
);
   import ecc_err_log_pkg::*;

   logic [REG_W-1:0] pick;

   always_comb begin
      unique case (reg_sel_e'(sel))
         SEL_ADDR: pick = ear_q;
         SEL_SYN:  pick = esr_q;
         default:  pick = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd) begin
         rdata <= pick;
      end
   end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
   parameter int ADDR_W = 27,
   parameter int CODE_W = 7,
   localparam int REG_W  = ADDR_W + ecc_err_log_pkg::ATTR_W,
   localparam int HALF_W = 2 * CODE_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_vld,
   input  logic [CODE_W-1:0] hi_chk,
   input  logic [CODE_W-1:0] hi_syn,
   input  logic              hi_single,
   input  logic              lo_vld,
   input  logic [CODE_W-1:0] lo_chk,
   input  logic [CODE_W-1:0] lo_syn,
   input  logic              lo_single,
   input  logic              err_evt,
   input  logic              err_cpu,
   input  logic              err_write,
   input  logic              err_ecc,
   input  logic [ADDR_W-1:0] err_addr,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              irq
);
   import ecc_err_log_pkg::*;

   if (2 * HALF_W != REG_W) begin : g_bad_layout
      $error("two syndrome halves must fill one register");
   end

   logic [REG_W-1:0]  ear_q;
   logic [REG_W-1:0]  esr_q;
   logic              clr_ear;
   logic              clr_esr;
   logic              frozen;

   logic [1:0]              half_vld;
   logic [1:0][CODE_W-1:0]  half_chk;
   logic [1:0][CODE_W-1:0]  half_syn;
   logic [1:0]              half_sgl;

   assign clr_ear = bus_wr && (reg_sel_e'(bus_sel) == SEL_ADDR);
   assign clr_esr = bus_wr && (reg_sel_e'(bus_sel) == SEL_SYN);
   assign frozen  = ear_q[REG_W-1];
   assign irq     = frozen;

   assign half_vld = {hi_vld, lo_vld};
   assign half_chk = {hi_chk, lo_chk};
   assign half_syn = {hi_syn, lo_syn};
   assign half_sgl = {hi_single, lo_single};

   ecc_err_addr_reg #(.ADDR_W(ADDR_W)) u_ear (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_req   (err_evt),
      .cap_cpu   (err_cpu),
      .cap_write (err_write),
      .cap_ecc   (err_ecc),
      .cap_addr  (err_addr),
      .clr       (clr_ear),
      .ear_q     (ear_q)
   );

   for (genvar h = 0; h < 2; h++) begin : g_half
      ecc_err_syn_half #(.CODE_W(CODE_W)) u_half (
         .clk    (clk),
         .rst_n  (rst_n),
         .upd    (half_vld[h] && !frozen),
         .chk    (half_chk[h]),
         .syn    (half_syn[h]),
         .single (half_sgl[h]),
         .clr    (clr_esr),
         .half_q (esr_q[h*HALF_W +: HALF_W])
      );
   end

   ecc_err_rd_port #(.REG_W(REG_W)) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (bus_rd),
      .sel   (bus_sel),
      .ear_q (ear_q),
      .esr_q (esr_q),
      .rdata (bus_rdata)
   );

endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
   parameter int ADDR_W = 27,
   parameter int CODE_W = 7,
   localparam int REG_W = ADDR_W + 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic              err_evt,
   input logic [ADDR_W-1:0] err_addr,
   input logic              bus_wr,
   input logic              bus_sel,
   input logic              bus_rd,
   input logic [REG_W-1:0]  bus_rdata,
   input logic              lo_vld,
   input logic [CODE_W-1:0] lo_syn,
   input logic [REG_W-1:0]  ear_q,
   input logic [REG_W-1:0]  esr_q
);

   AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (err_evt && !irq && !(bus_wr && !bus_sel)) |=> (irq && ear_q[ADDR_W-1:0] == $past(err_addr))); // R2
   AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(bus_wr && !bus_sel)) |=> $stable(ear_q)); // R3
   AST_IRQ_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_sel) |=> (bus_rdata[REG_W-1] == $past(irq))); // R4
   AST_SYN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && lo_vld && !(bus_wr && bus_sel)) |=> (esr_q[CODE_W-1:0] == $past(lo_syn))); // R5
   AST_SYN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(bus_wr && bus_sel)) |=> $stable(esr_q)); // R6
   AST_SYN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel) |=> (esr_q == '0)); // R7
   AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_sel) |=> (ear_q == '0 && !irq)); // R8
   AST_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> (bus_rdata == (($past(bus_sel)) ? $past(esr_q) : $past(ear_q)))); // R9

endmodule

bind ecc_err_log ecc_err_log_chk #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq       (irq),
   .err_evt   (err_evt),
   .err_addr  (err_addr),
   .bus_wr    (bus_wr),
   .bus_sel   (bus_sel),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .lo_vld    (lo_vld),
   .lo_syn    (lo_syn),
   .ear_q     (ear_q),
   .esr_q     (esr_q)
);

// File: tb/ecc_err_log_test.sv
`timescale 1ns/100ps
module ecc_err_log_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hi_vld = 0, lo_vld = 0, hi_single = 0, lo_single = 0;
   logic [6:0]  hi_chk = 0, hi_syn = 0, lo_chk = 0, lo_syn = 0;
   logic        err_evt = 0, err_cpu = 0, err_write = 0, err_ecc = 0;
   logic [26:0] err_addr = 0;
   logic        bus_sel = 0, bus_wr = 0, bus_rd = 0;
   logic [31:0] bus_rdata;
   logic        irq;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   string cur_req = "R1";

   logic [31:0] ear_m = 0, esr_m = 0, rd_m = 0;

   always #2.5 clk = ~clk;

   ecc_err_log uut (
      .clk(clk), .rst_n(rst_n),
      .hi_vld(hi_vld), .hi_chk(hi_chk), .hi_syn(hi_syn), .hi_single(hi_single),
      .lo_vld(lo_vld), .lo_chk(lo_chk), .lo_syn(lo_syn), .lo_single(lo_single),
      .err_evt(err_evt), .err_cpu(err_cpu), .err_write(err_write), .err_ecc(err_ecc),
      .err_addr(err_addr), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [15:0] half_f(logic [6:0] c, logic [6:0] s, logic sg);
      return {(s != 0), c, sg, s};
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic idle();
      hi_vld = 0; lo_vld = 0; err_evt = 0; bus_wr = 0; bus_rd = 0;
   endtask

   task automatic tick();
      logic [31:0] ear_n, esr_n, rd_n;
      ear_n = ear_m; esr_n = esr_m; rd_n = rd_m;
      if (bus_rd) rd_n = bus_sel ? esr_m : ear_m;
      if (!ear_m[31] && err_evt) ear_n = {1'b1, err_cpu, err_write, err_ecc, 1'b0, err_addr};
      if (bus_wr && !bus_sel) ear_n = 0;
      if (!ear_m[31]) begin
         if (lo_vld) esr_n[15:0]  = half_f(lo_chk, lo_syn, lo_single);
         if (hi_vld) esr_n[31:16] = half_f(hi_chk, hi_syn, hi_single);
      end
      if (bus_wr && bus_sel) esr_n = 0;
      @(posedge clk);
      #1;
      ear_m = ear_n; esr_m = esr_n; rd_m = rd_n;
      check({cur_req, " irq"}, {31'b0, irq}, {31'b0, ear_m[31]});
      check({cur_req, " rdata"}, bus_rdata, rd_m);
   endtask

   task automatic read_reg(logic sel);
      idle(); bus_rd = 1; bus_sel = sel;
      tick();
      idle();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog got=hang exp=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      cur_req = "R1";
      check("R1 irq", {31'b0, irq}, 32'd0);
      read_reg(0); read_reg(1);

      cur_req = "R5";
      idle(); lo_vld = 1; lo_chk = 7'h11; lo_syn = 7'h05; lo_single = 1;
      hi_vld = 1; hi_chk = 7'h22; hi_syn = 7'h00; hi_single = 0;
      tick(); read_reg(1);
      idle(); hi_vld = 1; hi_chk = 7'h3c; hi_syn = 7'h7f; hi_single = 0;
      tick(); read_reg(1);

      cur_req = "R10";
      idle(); err_evt = 1; err_cpu = 1; err_write = 0; err_ecc = 1; err_addr = 27'h5a5a5a5;
      lo_vld = 1; lo_chk = 7'h01; lo_syn = 7'h41; lo_single = 1;
      tick(); read_reg(1);
      cur_req = "R2"; read_reg(0);
      cur_req = "R4"; tick();

      cur_req = "R3";
      idle(); err_evt = 1; err_cpu = 0; err_write = 1; err_ecc = 0; err_addr = 27'h0000123;
      tick(); read_reg(0);
      cur_req = "R6";
      idle(); lo_vld = 1; hi_vld = 1; lo_syn = 7'h12; hi_syn = 7'h34;
      tick(); read_reg(1);

      cur_req = "R7";
      idle(); bus_wr = 1; bus_sel = 1; tick(); read_reg(1); read_reg(0);
      cur_req = "R8";
      idle(); bus_wr = 1; bus_sel = 0; err_evt = 1; err_addr = 27'h7ffffff;
      tick(); read_reg(0);
      idle(); err_evt = 1; err_cpu = 0; err_write = 1; err_ecc = 0; err_addr = 27'h2468ace;
      tick(); read_reg(0);
      cur_req = "R7";
      idle(); bus_wr = 1; bus_sel = 0; tick();
      idle(); lo_vld = 1; lo_syn = 7'h09; bus_wr = 1; bus_sel = 1; tick(); read_reg(1);

      cur_req = "R9";
      for (int i = 0; i < 4000; i++) begin
         err_evt   = ($urandom % 8) == 0;
         err_cpu   = $urandom; err_write = $urandom; err_ecc = $urandom;
         err_addr  = $urandom;
         lo_vld    = $urandom; hi_vld = $urandom;
         lo_chk    = $urandom; hi_chk = $urandom;
         lo_syn    = (($urandom % 4) == 0) ? 7'd0 : 7'($urandom);
         hi_syn    = (($urandom % 4) == 0) ? 7'd0 : 7'($urandom);
         lo_single = $urandom; hi_single = $urandom;
         bus_wr    = ($urandom % 12) == 0;
         bus_rd    = $urandom;
         bus_sel   = $urandom;
         tick();
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule